// File: doc/BRIEF.md
# Halfword and Signed-Byte Load/Store Unit

This block carries out a single halfword or signed-byte memory transfer. The transfer is described by a 32-bit instruction word. The caller presents the word together with three values: the base register, an optional offset register, and the value of the transfer register for stores. The block then decodes the word and forms an 8-bit immediate from two separated nibbles, or takes the offset register instead. It adds or subtracts the offset and picks the transfer address, before or after indexing. It issues one request on a valid/ready memory port.

For loads, it waits for the response and widens the returned value to the full register width, either with zero fill or with sign fill. On completion, it pulses a destination-register write, a base-register write-back, or both. It also pulses a completion strobe. The unit takes no new word until that strobe has been given.

Words that this unit cannot execute make no memory request and write no register. There are three such cases: a malformed fixed-bit pattern, a swap encoding, and a write-back bit set with post-indexing. Each case is reported by its own one-cycle flag, together with the completion strobe.

Top module: `hs_ldst_unit`

## Requirements
- R1: When word bit 22 is 1, the offset is the unsigned 8-bit value {bits 11:8, bits 3:0}, with bit 11 as the MSB. When bit 22 is 0, the offset is `in_offreg`, and the immediate nibbles have no effect.
- R2: When word bit 23 is 1, the modified base is base plus offset. When bit 23 is 0, it is base minus offset, modulo 2^DW.
- R3: When word bit 24 is 1 (pre-index), `mem_addr` is the modified base. When bit 24 is 0 (post-index), `mem_addr` is the unmodified base.
- R4: Write-back (`rn_we`, with `rn_data` equal to the modified base) happens in two cases: pre-index with bit 21 equal to 1, and post-index in every case. Pre-index with bit 21 equal to 0 gives no `rn_we`. `rn_idx` is bits 19:16.
- R5: When bit 24 is 0 and bit 21 is 1, the unit pulses `err_wbpost` with `done`. It makes no memory request and raises no `rd_we` or `rn_we`.
- R6: A data-type field (bits 6:5) of 00 pulses `err_unsup` with `done`. It makes no memory request and writes no register.
- R7: Bits 27:25 not equal to 000, or bit 7 or bit 4 equal to 0, pulses `err_form` with `done`. It makes no memory request and writes no register.
- R8: When bit 20 is 1, the unit loads: `mem_we`=0, and `rd_we` pulses with `rd_idx` equal to bits 15:12. When bit 20 is 0, the unit stores: `mem_we`=1, `mem_wdata` equals `in_rdval[15:0]` zero-extended, `mem_be`=0011, and there is no `rd_we`.
- R9: For a load, data type 01 gives `rd_data` = `mem_rdata[15:0]` with zero fill, and `mem_be`=0011. Data type 10 gives `mem_rdata[7:0]` with bit 7 copied upward, and `mem_be`=0001. Data type 11 gives `mem_rdata[15:0]` with bit 15 copied upward, and `mem_be`=0011.
- R10: `mem_req_valid` stays high with `mem_addr` stable until `mem_req_ready`. `in_ready` is low from acceptance until the cycle after `done`. It is high after reset, when no request is pending.
- R11: `done`, `rd_we` and `rn_we` are single-cycle pulses, and they occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Unit idle, word accepted when valid |
| in_instr | input | 32 | Instruction word |
| in_base | input | DW | Base register value |
| in_offreg | input | DW | Offset register value |
| in_rdval | input | DW | Transfer register value for stores |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | DW | Byte address |
| mem_be | output | DW/8 | Byte-lane enables |
| mem_wdata | output | DW | Store data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| rd_we | output | 1 | Destination register write pulse |
| rd_idx | output | 4 | Destination register index |
| rd_data | output | DW | Extended load value |
| rn_we | output | 1 | Base write-back pulse |
| rn_idx | output | 4 | Base register index |
| rn_data | output | DW | Modified base |
| done | output | 1 | Operation finished |
| err_form | output | 1 | Malformed fixed bits |
| err_unsup | output | 1 | Swap encoding rejected |
| err_wbpost | output | 1 | Write-back bit with post-index |

## Verification
The in-RTL properties check several behaviours on every cycle:
- the memory request is held with a stable address until it is accepted;
- `in_ready` stays low while a request is outstanding;
- a rejected word never reaches the memory port;
- post-indexed completions always write back;
- unsigned-halfword results carry zero upper bits;
- the write strobes are single-cycle pulses.

Only the scoreboard scenarios can show the arithmetic itself. That covers the split-nibble immediate, add versus subtract with wraparound, and the choice of pre- or post-index address. They also show the sign or zero fill for each data type, and the exact byte enables and store data, against independently computed values.

// File: rtl/hs_ldst_pkg.sv
package hs_ldst_pkg;

  typedef enum logic [1:0] {
    DT_SWAP  = 2'b00,
    DT_UHALF = 2'b01,
    DT_SBYTE = 2'b10,
    DT_SHALF = 2'b11
  } dtype_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RSP,
    ST_DONE,
    ST_ERR
  } state_e;

  typedef struct packed {
    logic       pre;
    logic       up;
    logic       imm_sel;
    logic       wbit;
    logic       load;
    logic [3:0] rn;
    logic [3:0] rd;
    dtype_e     dt;
    logic [7:0] imm8;
    logic       bad_form;
    logic       unsup;
    logic       bad_wb;
  } dec_t;

endpackage

// File: rtl/hs_decode.sv
module hs_decode
  import hs_ldst_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);
  always_comb begin
    dec.pre      = instr[24];
    dec.up       = instr[23];
    dec.imm_sel  = instr[22];
    dec.wbit     = instr[21];
    dec.load     = instr[20];
    dec.rn       = instr[19:16];
    dec.rd       = instr[15:12];
    dec.dt       = dtype_e'(instr[6:5]);
    dec.imm8     = {instr[11:8], instr[3:0]};
    dec.bad_form = (instr[27:25] != 3'b000) || !instr[7] || !instr[4];
    dec.unsup    = (instr[6:5] == 2'b00);
    dec.bad_wb   = !instr[24] && instr[21];
  end
endmodule

// File: rtl/hs_addr_gen.sv
module hs_addr_gen
  import hs_ldst_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] offreg,
  input  dec_t          dec,
  output logic [DW-1:0] addr,
  output logic [DW-1:0] new_base,
  output logic          do_wb
);
  logic [DW-1:0] offset;

  always_comb begin
    offset   = dec.imm_sel ? DW'(dec.imm8) : offreg;
    new_base = dec.up ? (base + offset) : (base - offset);
    addr     = dec.pre ? new_base : base;
    do_wb    = !dec.pre || dec.wbit;
  end
endmodule

// File: rtl/hs_load_ext.sv
module hs_load_ext
  import hs_ldst_pkg::*;
#(
  parameter int DW = 32
) (
  input  dtype_e        dt,
  input  logic [DW-1:0] raw,
  output logic [DW-1:0] ext
);
  localparam logic [DW-1:0] HALF_MASK = DW'(16'hFFFF);

  logic [DW-1:0] lane;

  always_comb begin
    lane = raw & HALF_MASK;
    unique case (dt)
      DT_SBYTE: ext = {{(DW-8){lane[7]}}, lane[7:0]};
      DT_SHALF: ext = {{(DW-16){lane[15]}}, lane[15:0]};
      default:  ext = lane;
    endcase
  end
endmodule

// File: rtl/hs_ldst_unit.sv
module hs_ldst_unit
  import hs_ldst_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     in_instr,
  input  logic [DW-1:0]   in_base,
  input  logic [DW-1:0]   in_offreg,
  input  logic [DW-1:0]   in_rdval,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_we,
  output logic [DW-1:0]   mem_addr,
  output logic [DW/8-1:0] mem_be,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_rsp_valid,
  input  logic [DW-1:0]   mem_rdata,
  output logic            rd_we,
  output logic [3:0]      rd_idx,
  output logic [DW-1:0]   rd_data,
  output logic            rn_we,
  output logic [3:0]      rn_idx,
  output logic [DW-1:0]   rn_data,
  output logic            done,
  output logic            err_form,
  output logic            err_unsup,
  output logic            err_wbpost
);
  localparam int BEW = DW / 8;
  localparam logic [BEW-1:0] BE_HALF = BEW'(2'b11);
  localparam logic [BEW-1:0] BE_BYTE = BEW'(1'b1);
  localparam logic [DW-1:0]  HALF_MASK = DW'(16'hFFFF);

  state_e        st;
  dec_t          dec_c, d_q;
  logic [DW-1:0] addr_c, nb_c, addr_q, nb_q, wdata_q, ld_q, ext_c;
  logic          wb_c, wb_q;
  logic          accept, reject_c;

  hs_decode u_dec (.instr(in_instr), .dec(dec_c));

  hs_addr_gen #(.DW(DW)) u_agen (
    .base(in_base), .offreg(in_offreg), .dec(dec_c),
    .addr(addr_c), .new_base(nb_c), .do_wb(wb_c)
  );

  hs_load_ext #(.DW(DW)) u_ext (.dt(d_q.dt), .raw(mem_rdata), .ext(ext_c));

  assign accept   = in_valid && in_ready;
  assign reject_c = dec_c.bad_form || dec_c.unsup || dec_c.bad_wb;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      d_q     <= '0;
      addr_q  <= '0;
      nb_q    <= '0;
      wdata_q <= '0;
      ld_q    <= '0;
      wb_q    <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          d_q     <= dec_c;
          addr_q  <= addr_c;
          nb_q    <= nb_c;
          wb_q    <= wb_c;
          wdata_q <= in_rdval & HALF_MASK;
          st      <= reject_c ? ST_ERR : ST_REQ;
        end
        ST_REQ: if (mem_req_ready) st <= d_q.load ? ST_RSP : ST_DONE;
        ST_RSP: if (mem_rsp_valid) begin
          ld_q <= ext_c;
          st   <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    in_ready      = (st == ST_IDLE);
    mem_req_valid = (st == ST_REQ);
    mem_we        = !d_q.load;
    mem_addr      = addr_q;
    mem_be        = (d_q.load && d_q.dt == DT_SBYTE) ? BE_BYTE : BE_HALF;
    mem_wdata     = wdata_q;
    rd_we         = (st == ST_DONE) && d_q.load;
    rd_idx        = d_q.rd;
    rd_data       = ld_q;
    rn_we         = (st == ST_DONE) && wb_q;
    rn_idx        = d_q.rn;
    rn_data       = nb_q;
    done          = (st == ST_DONE) || (st == ST_ERR);
    err_form      = (st == ST_ERR) && d_q.bad_form;
    err_unsup     = (st == ST_ERR) && d_q.unsup;
    err_wbpost    = (st == ST_ERR) && d_q.bad_wb;
  end

  // R10: request held with stable address until accepted
  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));

  // R10: no new word while a request is outstanding
  p_busy_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !in_ready);

  // R5 R6 R7: a rejected word never reaches memory
  p_reject_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (err_form || err_unsup || err_wbpost) |-> (!mem_req_valid && !rd_we && !rn_we));

  // R4: post-indexed completion always writes back
  p_post_wb_r4: assert property (@(posedge clk) disable iff (rst)
    (done && !(err_form || err_unsup || err_wbpost) && !d_q.pre) |-> rn_we);

  // R9: unsigned halfword leaves upper bits zero
  p_uhalf_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_we && d_q.dt == DT_UHALF) |-> ((rd_data & ~HALF_MASK) == '0));

  // R11: strobes last one cycle
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_wr_with_done_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_we || rn_we) |-> done);

endmodule

// File: tb/hs_ldst_unit_bench.sv
module hs_ldst_unit_bench;
  localparam int DW = 32;

  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic [31:0] rdata;
    int          lat;
  } req_t;

  typedef struct {
    logic        ef, eu, ew;
    logic        rdw;
    logic [3:0]  rdi;
    logic [31:0] rdd;
    logic        rnw;
    logic [3:0]  rni;
    logic [31:0] rnd;
    string       tag;
  } fin_t;

  logic clk = 0, rst = 1;
  logic in_valid = 0, mem_req_ready = 0, mem_rsp_valid = 0;
  logic [31:0] in_instr = '0, in_base = '0, in_offreg = '0, in_rdval = '0, mem_rdata = '0;
  logic in_ready, mem_req_valid, mem_we, rd_we, rn_we, done, err_form, err_unsup, err_wbpost;
  logic [31:0] mem_addr, mem_wdata, rd_data, rn_data;
  logic [3:0] mem_be, rd_idx, rn_idx;

  int checks = 0, errors = 0;
  req_t req_q[$];
  fin_t fin_q[$];

  always #10 clk = ~clk;

  hs_ldst_unit #(.DW(DW)) u_hs_ldst_unit (
    .clk, .rst, .in_valid, .in_ready, .in_instr, .in_base, .in_offreg, .in_rdval,
    .mem_req_valid, .mem_req_ready, .mem_we, .mem_addr, .mem_be, .mem_wdata,
    .mem_rsp_valid, .mem_rdata, .rd_we, .rd_idx, .rd_data, .rn_we, .rn_idx, .rn_data,
    .done, .err_form, .err_unsup, .err_wbpost
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(bit p, bit u, bit i, bit w, bit l, logic [3:0] rn,
                                     logic [3:0] rd, logic [1:0] sh, logic [3:0] hi, logic [3:0] lo);
    return {4'hE, 3'b000, p, u, i, w, l, rn, rd, hi, 1'b1, sh, 1'b1, lo};
  endfunction

  // driver: computes expectations from the requirements, then offers the word
  task automatic send(logic [31:0] w, logic [31:0] base, logic [31:0] offr,
                      logic [31:0] rdv, logic [31:0] rdat, int lat, string tag);
    logic [31:0] off, nb, addr, ext;
    logic bf, us, bw, rej, ld;
    req_t r;
    fin_t f;
    off  = w[22] ? {24'h0, w[11:8], w[3:0]} : offr;            // R1
    nb   = w[23] ? base + off : base - off;                    // R2
    addr = w[24] ? nb : base;                                   // R3
    bf   = (w[27:25] != 0) || !w[7] || !w[4];                  // R7
    us   = (w[6:5] == 2'b00);                                   // R6
    bw   = !w[24] && w[21];                                     // R5
    rej  = bf || us || bw;
    ld   = w[20];                                               // R8
    case (w[6:5])                                               // R9
      2'b10:   ext = {{24{rdat[7]}}, rdat[7:0]};
      2'b11:   ext = {{16{rdat[15]}}, rdat[15:0]};
      default: ext = {16'h0, rdat[15:0]};
    endcase
    if (!rej) begin
      r.we = !ld; r.addr = addr; r.be = (ld && w[6:5] == 2'b10) ? 4'b0001 : 4'b0011;
      r.wdata = {16'h0, rdv[15:0]}; r.rdata = rdat; r.lat = lat;
      req_q.push_back(r);
    end
    f.ef = bf; f.eu = us; f.ew = bw; f.tag = tag;
    f.rdw = !rej && ld; f.rdi = w[15:12]; f.rdd = ext;
    f.rnw = !rej && (!w[24] || w[21]); f.rni = w[19:16]; f.rnd = nb;   // R4
    fin_q.push_back(f);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_instr = w; in_base = base; in_offreg = offr; in_rdval = rdv;
    @(negedge clk);
    in_valid = 0;
    chk({tag, " R10 in_ready low after accept"}, {31'h0, in_ready}, 32'h0);
  endtask

  // memory model: checks each request and answers
  initial begin
    req_t cur;
    bit seen = 0;
    int wt = 0, rp = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      if (rp > 0) begin
        rp--;
        if (rp == 0) begin mem_rsp_valid = 1; mem_rdata = cur.rdata; end
      end
      if (mem_req_ready) begin
        mem_req_ready = 0; seen = 0;
        if (!cur.we) rp = cur.lat + 1;
      end else if (mem_req_valid) begin
        if (!seen) begin
          seen = 1;
          if (req_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R5 unexpected memory request actual=%h expected=none", mem_addr);
          end else begin
            cur = req_q.pop_front();
            chk("R3 mem_addr", mem_addr, cur.addr);
            chk("R8 mem_we", {31'h0, mem_we}, {31'h0, cur.we});
            chk("R9 mem_be", {28'h0, mem_be}, {28'h0, cur.be});
            if (cur.we) chk("R8 mem_wdata", mem_wdata, cur.wdata);
          end
          wt = cur.lat;
        end
        if (wt == 0) mem_req_ready = 1; else wt--;
      end
    end
  end

  // monitor: pops expected completions
  initial begin
    fin_t f;
    forever begin
      @(negedge clk);
      if (!rst && (rd_we || rn_we) && !done) begin
        checks++; errors++;
        $display("FAIL R11 write without done actual=%b%b expected=00", rd_we, rn_we);
      end
      if (!rst && done) begin
        if (fin_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R11 unexpected done actual=1 expected=0");
        end else begin
          f = fin_q.pop_front();
          chk({f.tag, " R7 err_form"}, {31'h0, err_form}, {31'h0, f.ef});
          chk({f.tag, " R6 err_unsup"}, {31'h0, err_unsup}, {31'h0, f.eu});
          chk({f.tag, " R5 err_wbpost"}, {31'h0, err_wbpost}, {31'h0, f.ew});
          chk({f.tag, " R8 rd_we"}, {31'h0, rd_we}, {31'h0, f.rdw});
          chk({f.tag, " R4 rn_we"}, {31'h0, rn_we}, {31'h0, f.rnw});
          if (f.rdw) begin
            chk({f.tag, " R8 rd_idx"}, {28'h0, rd_idx}, {28'h0, f.rdi});
            chk({f.tag, " R9 rd_data"}, rd_data, f.rdd);
          end
          if (f.rnw) begin
            chk({f.tag, " R4 rn_idx"}, {28'h0, rn_idx}, {28'h0, f.rni});
            chk({f.tag, " R2 rn_data"}, rn_data, f.rnd);
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R10 reset in_ready", {31'h0, in_ready}, 32'h1);
    chk("R10 reset mem_req_valid", {31'h0, mem_req_valid}, 32'h0);
    chk("R11 reset done", {31'h0, done}, 32'h0);
    // R1 R3: pre, up, imm, no write-back, unsigned halfword load
    send(mk(1,1,1,0,1,4'd2,4'd5,2'b01,4'h5,4'hA), 32'h1000, 32'h0, 0, 32'hFFFF8234, 0, "t1");
    // R9: pre, up, imm, write-back, signed byte load, negative
    send(mk(1,1,1,1,1,4'd3,4'd6,2'b10,4'h0,4'h4), 32'h2000, 32'h0, 0, 32'h12345680, 1, "t2");
    // R1: register offset, imm nibbles ignored; pre down write-back signed half
    send(mk(1,0,0,1,1,4'd4,4'd7,2'b11,4'hF,4'h9), 32'h3000, 32'h100, 0, 32'h00009ABC, 2, "t3");
    // R4 R8: post up imm store, always writes back
    send(mk(0,1,1,0,0,4'd1,4'd8,2'b01,4'h1,4'h0), 32'h4000, 32'h0, 32'hDEADBEEF, 0, 0, "t4");
    // R3: post down register offset, signed byte positive
    send(mk(0,0,0,0,1,4'd9,4'd10,2'b10,4'h0,4'h2), 32'h5000, 32'h44, 0, 32'hFFFFFF7F, 3, "t5");
    // R4: pre down imm 0xFF, no write-back, store
    send(mk(1,0,1,0,0,4'd11,4'd12,2'b11,4'hF,4'hF), 32'h200, 32'h0, 32'h0000CAFE, 0, 2, "t6");
    // R2: wraparound subtract
    send(mk(1,0,1,1,1,4'd13,4'd14,2'b11,4'h2,4'h0), 32'h10, 32'h0, 0, 32'h00007FFF, 0, "t7");
    // R5: post with write-back bit set
    send(mk(0,1,1,1,1,4'd1,4'd2,2'b01,4'h0,4'h1), 32'h6000, 32'h0, 0, 0, 0, "t8");
    // R6: swap encoding
    send(mk(1,1,1,0,1,4'd1,4'd2,2'b00,4'h0,4'h1), 32'h6000, 32'h0, 0, 0, 0, "t9");
    // R7: bad fixed bits 27:25 and bit 7
    send(mk(1,1,1,0,1,4'd1,4'd2,2'b01,4'h0,4'h1) | 32'h0200_0000, 32'h6000, 32'h0, 0, 0, 0, "t10");
    send(mk(1,1,1,0,1,4'd1,4'd2,2'b01,4'h0,4'h1) & ~32'h80, 32'h6000, 32'h0, 0, 0, 0, "t11");
    // R11: back-to-back after a rejection
    send(mk(0,1,0,0,1,4'd15,4'd0,2'b11,4'h0,4'h0), 32'hFFFFFFF0, 32'h20, 0, 32'h00018001, 1, "t12");
    while (fin_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R10 idle in_ready", {31'h0, in_ready}, 32'h1);
    chk("R5 no leftover requests", req_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule